// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, from the 48-bit destination address of an incoming frame, whether the frame is kept and which of eight receive channels gets it. It holds a 32-entry address table. Each entry is an address with a valid flag, a kind flag and a channel number. An entry of the *admit* kind accepts a frame whose address it hits. An entry of the *reject* kind drops that frame. Frames that hit no entry fall through to fixed rules. Broadcast frames follow a broadcast enable. Other group (multicast) frames follow a 64-bit hash table. Unicast frames are dropped.

Entries are loaded through a valid/ready write port that carries an index and the entry fields. Each entry is stored as 53 bits: the address, the valid flag, the kind flag and a 3-bit channel. Lookups enter through a second valid/ready port. The table has a single read port, so a lookup walks the table one entry per clock, and the decision comes out 32 cycles after the lookup is taken. A lookup port never accepts a second address while a walk is running. A one-deep holding slot lets one table write arrive during a walk without disturbing it.

Back-pressure rules: a lookup is taken on a clock edge where `lkp_valid` and `lkp_ready` are both high. `lkp_ready` is low while a walk runs, and also while a held write is waiting to land. A write is taken on an edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while the holding slot is full. The per-channel enables, the hash enable, the hash table, the broadcast enable and the default channels are plain configuration inputs. They must be kept stable while `busy` is high.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `busy`, `res_valid`, `res_accept` and `res_chan` are 0, both ready outputs are 1, and every table entry is invalid, so a unicast lookup is dropped.
- R2: A lookup taken at clock edge T gives a one-cycle `res_valid` pulse right after edge T+32. `busy` is high from T+1 until that same edge.
- R3: While `busy` is high, `lkp_ready` is low and an offered lookup is not taken. The pending result belongs to the address taken first.
- R4: A valid admit entry whose address equals the lookup address, and whose channel has its `uc_en` bit set, accepts the frame on that entry's channel.
- R5: A valid reject entry that hits drops the frame, even when the address is a group address and its hash bit would accept it.
- R6: An entry counts as hit only when `uc_en[entry channel]` is 1, and this holds for group addresses too. `hash_en` has no effect on table hits, so a group address can be accepted by an admit entry while `hash_en` is 0.
- R7: When several valid entries hit, the lowest-numbered one decides.
- R8: A group address is one with bit 40 set (bit 40 is the lowest bit of the first octet; the first octet is bits 47:40). A group address that is not broadcast and hits no entry is accepted on `mc_chan` exactly when `hash_en` is 1 and `hash_tbl[h]` is 1. Here `h` is the XOR of the eight 6-bit slices `mac[6k+5:6k]`, for k = 0 to 7.
- R9: The all-ones address, when it hits no entry, is accepted on `bc_chan` exactly when `bcast_en` is 1. The hash is not consulted.
- R10: A unicast address that hits no entry is dropped. Every dropped frame reports `res_chan` = 0.
- R11: A write taken while `busy` is high does not change the running walk. It is applied after the walk ends and before the next lookup is taken. A second write during the same walk sees `wr_ready` low.
- R12: `res_accept` and `res_chan` change only together with a `res_valid` pulse. They hold their value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Table write offered |
| wr_ready | output | 1 | Table write can be taken |
| wr_idx | input | 5 | Entry index to write |
| wr_mac | input | 48 | Entry address |
| wr_used | input | 1 | Entry valid flag |
| wr_admit | input | 1 | 1 = admit entry, 0 = reject entry |
| wr_chan | input | 3 | Entry channel |
| lkp_valid | input | 1 | Lookup offered |
| lkp_ready | output | 1 | Lookup can be taken |
| lkp_mac | input | 48 | Destination address to classify |
| uc_en | input | 8 | Per-channel enable for table hits |
| hash_en | input | 1 | Enable group-address hash acceptance |
| hash_tbl | input | 64 | Group-address hash bits |
| bcast_en | input | 1 | Enable broadcast acceptance |
| mc_chan | input | 3 | Channel for hash-accepted group frames |
| bc_chan | input | 3 | Channel for accepted broadcast frames |
| busy | output | 1 | Table walk in progress |
| res_valid | output | 1 | One-cycle pulse: new decision |
| res_accept | output | 1 | Decision: 1 = keep frame |
| res_chan | output | 3 | Channel of the decision, 0 when dropped |

## Verification
On every cycle, the assertions check the following. The walk stays busy until its last entry. A result pulse follows the end of a walk. The decision outputs hold between pulses. Dropped frames report channel 0. The captured address stays fixed during a walk. A write taken mid-walk waits in the holding slot. Only the bench scenarios can show the rest, because it depends on table contents. That covers the choice between admit and reject entries, lowest-index priority, gating by channel enable, the hash fold and the broadcast rule. It also covers the exact 32-cycle latency, and the fact that a mid-walk write affects the next lookup and not the current one.

// File: rtl/raf_pkg.sv
package raf_pkg;
  localparam int ADDR_W    = 48;
  localparam int CHAN_W    = 3;
  localparam int N_CHAN    = 1 << CHAN_W;
  localparam int HASH_W    = 6;
  localparam int HASH_BITS = 1 << HASH_W;
  localparam int GROUP_BIT = ADDR_W - 8;

  typedef struct packed {
    logic [ADDR_W-1:0] mac;
    logic              valid;
    logic              admit;
    logic [CHAN_W-1:0] chan;
  } raf_entry_t;

  // fold every address bit into one of HASH_W positions
  function automatic logic [HASH_W-1:0] hash_fold(input logic [ADDR_W-1:0] a);
    logic [HASH_W-1:0] h;
    h = '0;
    for (int i = 0; i < ADDR_W; i++) h[i % HASH_W] ^= a[i];
    return h;
  endfunction

  function automatic logic is_group(input logic [ADDR_W-1:0] a);
    return a[GROUP_BIT];
  endfunction

  function automatic logic is_bcast(input logic [ADDR_W-1:0] a);
    return &a;
  endfunction
endpackage

// File: rtl/raf_table.sv
module raf_table
  import raf_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [IDX_W-1:0] wr_idx,
  input  raf_entry_t       wr_entry,
  input  logic             busy,
  output logic             hold_pend,
  input  logic [IDX_W-1:0] rd_idx,
  output raf_entry_t       rd_entry
);
  raf_entry_t       mem [DEPTH];
  raf_entry_t       pend_entry;
  logic [IDX_W-1:0] pend_idx;
  logic             pend_full;

  assign wr_ready  = !pend_full;
  assign hold_pend = pend_full;
  assign rd_entry  = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      pend_entry <= '0;
      pend_idx   <= '0;
      pend_full  <= 1'b0;
    end else if (pend_full && !busy) begin
      mem[pend_idx] <= pend_entry;
      pend_full     <= 1'b0;
    end else if (wr_valid && wr_ready) begin
      if (busy) begin
        pend_entry <= wr_entry;
        pend_idx   <= wr_idx;
        pend_full  <= 1'b1;
      end else begin
        mem[wr_idx] <= wr_entry;
      end
    end
  end

  // R11: a write taken mid-walk is parked, and stays parked while the walk runs
  assert_park_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && busy |=> pend_full);
  assert_park_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_full && busy |=> pend_full);
endmodule

// File: rtl/raf_decide.sv
module raf_decide
  import raf_pkg::*;
(
  input  logic                 found,
  input  logic                 hit_admit,
  input  logic [CHAN_W-1:0]    hit_chan,
  input  logic [ADDR_W-1:0]    mac,
  input  logic                 hash_en,
  input  logic [HASH_BITS-1:0] hash_tbl,
  input  logic                 bcast_en,
  input  logic [CHAN_W-1:0]    mc_chan,
  input  logic [CHAN_W-1:0]    bc_chan,
  output logic                 accept,
  output logic [CHAN_W-1:0]    chan
);
  logic hash_ok;
  assign hash_ok = hash_en && hash_tbl[hash_fold(mac)];

  always_comb begin
    accept = 1'b0;
    chan   = '0;
    if (found) begin
      accept = hit_admit;
      chan   = hit_admit ? hit_chan : '0;
    end else if (is_bcast(mac)) begin
      accept = bcast_en;
      chan   = bcast_en ? bc_chan : '0;
    end else if (is_group(mac)) begin
      accept = hash_ok;
      chan   = hash_ok ? mc_chan : '0;
    end
  end
endmodule

// File: rtl/raf_search.sv
module raf_search
  import raf_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hold_pend,
  input  logic                 lkp_valid,
  output logic                 lkp_ready,
  input  logic [ADDR_W-1:0]    lkp_mac,
  output logic [IDX_W-1:0]     rd_idx,
  input  raf_entry_t           rd_entry,
  input  logic [N_CHAN-1:0]    uc_en,
  input  logic                 hash_en,
  input  logic [HASH_BITS-1:0] hash_tbl,
  input  logic                 bcast_en,
  input  logic [CHAN_W-1:0]    mc_chan,
  input  logic [CHAN_W-1:0]    bc_chan,
  output logic                 busy,
  output logic                 res_valid,
  output logic                 res_accept,
  output logic [CHAN_W-1:0]    res_chan
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic              busy_q, found_q, admit_q, rv_q, acc_q;
  logic [IDX_W-1:0]  ptr;
  logic [ADDR_W-1:0] mac_q;
  logic [CHAN_W-1:0] chan_q, rch_q;
  logic              hit_now, sel_found, sel_admit, dec_accept;
  logic [CHAN_W-1:0] sel_chan, dec_chan;

  assign lkp_ready  = !busy_q && !hold_pend;
  assign rd_idx     = ptr;
  assign busy       = busy_q;
  assign res_valid  = rv_q;
  assign res_accept = acc_q;
  assign res_chan   = rch_q;

  assign hit_now   = busy_q && rd_entry.valid && (rd_entry.mac == mac_q) && uc_en[rd_entry.chan];
  assign sel_found = found_q || hit_now;
  assign sel_admit = found_q ? admit_q : rd_entry.admit;
  assign sel_chan  = found_q ? chan_q  : rd_entry.chan;

  raf_decide u_decide (
    .found(sel_found), .hit_admit(sel_admit), .hit_chan(sel_chan), .mac(mac_q),
    .hash_en(hash_en), .hash_tbl(hash_tbl), .bcast_en(bcast_en),
    .mc_chan(mc_chan), .bc_chan(bc_chan), .accept(dec_accept), .chan(dec_chan)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; found_q <= 1'b0; admit_q <= 1'b0; chan_q <= '0;
      ptr    <= '0;   mac_q   <= '0;   rv_q    <= 1'b0; acc_q  <= 1'b0; rch_q <= '0;
    end else begin
      rv_q <= 1'b0;
      if (!busy_q) begin
        if (lkp_valid && lkp_ready) begin
          busy_q  <= 1'b1;
          ptr     <= '0;
          mac_q   <= lkp_mac;
          found_q <= 1'b0;
        end
      end else begin
        if (!found_q && hit_now) begin
          found_q <= 1'b1;
          admit_q <= rd_entry.admit;
          chan_q  <= rd_entry.chan;
        end
        ptr <= ptr + 1'b1;
        if (ptr == LAST) begin
          busy_q <= 1'b0;
          rv_q   <= 1'b1;
          acc_q  <= dec_accept;
          rch_q  <= dec_chan;
        end
      end
    end
  end

  // R2: the walk does not end before the last entry; a result follows a walk
  assert_walk_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (ptr != LAST) |=> busy_q);
  assert_result_after_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |-> $past(busy_q) && !busy_q);
  // R3: the address under search is frozen while busy
  assert_ignore_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(mac_q));
  // R10: a dropped frame reports channel zero
  assert_drop_chan_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q && !acc_q |-> rch_q == '0);
  // R12: decision outputs move only with a result pulse
  assert_hold_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rv_q |-> $stable(acc_q) && $stable(rch_q));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import raf_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [ADDR_W-1:0]    wr_mac,
  input  logic                 wr_used,
  input  logic                 wr_admit,
  input  logic [CHAN_W-1:0]    wr_chan,
  input  logic                 lkp_valid,
  output logic                 lkp_ready,
  input  logic [ADDR_W-1:0]    lkp_mac,
  input  logic [N_CHAN-1:0]    uc_en,
  input  logic                 hash_en,
  input  logic [HASH_BITS-1:0] hash_tbl,
  input  logic                 bcast_en,
  input  logic [CHAN_W-1:0]    mc_chan,
  input  logic [CHAN_W-1:0]    bc_chan,
  output logic                 busy,
  output logic                 res_valid,
  output logic                 res_accept,
  output logic [CHAN_W-1:0]    res_chan
);
  raf_entry_t       wr_entry, rd_entry;
  logic [IDX_W-1:0] rd_idx;
  logic             hold_pend;

  assign wr_entry = '{mac: wr_mac, valid: wr_used, admit: wr_admit, chan: wr_chan};

  raf_table #(.DEPTH(DEPTH)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_idx(wr_idx), .wr_entry(wr_entry), .busy(busy), .hold_pend(hold_pend),
    .rd_idx(rd_idx), .rd_entry(rd_entry)
  );

  raf_search #(.DEPTH(DEPTH)) u_search (
    .clk(clk), .rst_n(rst_n), .hold_pend(hold_pend),
    .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_mac(lkp_mac),
    .rd_idx(rd_idx), .rd_entry(rd_entry), .uc_en(uc_en), .hash_en(hash_en),
    .hash_tbl(hash_tbl), .bcast_en(bcast_en), .mc_chan(mc_chan), .bc_chan(bc_chan),
    .busy(busy), .res_valid(res_valid), .res_accept(res_accept), .res_chan(res_chan)
  );
endmodule

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_used = 1'b0, wr_admit = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [47:0] wr_mac = '0, lkp_mac = '0;
  logic [2:0]  wr_chan = '0, mc_chan = 3'd4, bc_chan = 3'd7;
  logic        lkp_valid = 1'b0, hash_en = 1'b0, bcast_en = 1'b0;
  logic [7:0]  uc_en = 8'hFF;
  logic [63:0] hash_tbl = '0;
  logic        wr_ready, lkp_ready, busy, res_valid, res_accept;
  logic [2:0]  res_chan;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  logic        m_valid [32];
  logic        m_admit [32];
  logic [2:0]  m_chan  [32];
  logic [47:0] m_mac   [32];

  rx_addr_filter dut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] bench_hash(input logic [47:0] a);
    logic [5:0] h = '0;
    for (int k = 0; k < 8; k++) h = h ^ a[6*k +: 6];
    return h;
  endfunction

  function automatic void expect_of(input logic [47:0] a, output logic acc, output logic [2:0] ch);
    acc = 1'b0; ch = 3'd0;
    for (int i = 0; i < 32; i++)
      if (m_valid[i] && m_mac[i] == a && uc_en[m_chan[i]]) begin
        acc = m_admit[i]; ch = m_admit[i] ? m_chan[i] : 3'd0;
        return;
      end
    if (&a) begin acc = bcast_en; ch = bcast_en ? bc_chan : 3'd0; end
    else if (a[40] && hash_en && hash_tbl[bench_hash(a)]) begin acc = 1'b1; ch = mc_chan; end
  endfunction

  task automatic write_entry(input int idx, input logic [47:0] mac, input logic used,
                             input logic admit, input logic [2:0] ch);
    @(negedge clk);
    wr_valid = 1; wr_idx = 5'(idx); wr_mac = mac; wr_used = used; wr_admit = admit; wr_chan = ch;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 0;
    m_valid[idx] = used; m_mac[idx] = mac; m_admit[idx] = admit; m_chan[idx] = ch;
  endtask

  // returns at the first negedge after the accepting edge; start = cycle count there
  task automatic start_lookup(input logic [47:0] mac, output int start);
    @(negedge clk);
    lkp_mac = mac; lkp_valid = 1;
    while (!lkp_ready) @(negedge clk);
    @(negedge clk);
    lkp_valid = 0;
    start = cyc;
  endtask

  task automatic finish_lookup(input int start, input logic e_acc, input logic [2:0] e_ch,
                               input logic p_acc, input logic [2:0] p_ch, input string req);
    int guard = 0;
    while (!res_valid && guard < 64) begin
      if (res_accept !== p_acc || res_chan !== p_ch)
        chk(0, "R12 hold", {res_accept, res_chan}, {p_acc, p_ch});
      @(negedge clk); guard++;
    end
    chk(res_valid && (cyc - start == 32), "R2 latency", 64'(cyc - start), 64'd32);
    chk(res_accept === e_acc, {req, " accept"}, res_accept, e_acc);
    chk(res_chan === e_ch, {req, " chan"}, res_chan, e_ch);
    @(negedge clk);
    chk(!res_valid && res_accept === e_acc && res_chan === e_ch, "R12 held after pulse",
        {res_valid, res_accept, res_chan}, {1'b0, e_acc, e_ch});
  endtask

  task automatic lookup(input logic [47:0] mac, input string req);
    logic ea; logic [2:0] ec; int st;
    logic pa; logic [2:0] pc;
    expect_of(mac, ea, ec);
    pa = res_accept; pc = res_chan;
    start_lookup(mac, st);
    finish_lookup(st, ea, ec, pa, pc, req);
  endtask

  localparam logic [47:0] UA = 48'h00_11_22_33_44_55;
  localparam logic [47:0] UB = 48'h02_AA_BB_CC_DD_EE;
  localparam logic [47:0] MA = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] MB = 48'h33_33_00_00_00_FB;
  localparam logic [47:0] BC = 48'hFF_FF_FF_FF_FF_FF;

  initial begin
    logic ea; logic [2:0] ec; int st;
    logic pa; logic [2:0] pc;
    logic [47:0] pool [6];
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) begin m_valid[i] = 0; m_admit[i] = 0; m_chan[i] = 0; m_mac[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!busy && !res_valid && !res_accept && res_chan == 0 && wr_ready && lkp_ready,
        "R1 reset outputs", {busy, res_valid, res_accept, res_chan, wr_ready, lkp_ready}, 8'b00000011);
    rst_n = 1;
    lookup(UA, "R1 empty table drop");

    write_entry(5, UA, 1, 1, 3'd3);
    lookup(UA, "R4 admit hit");
    uc_en = 8'hF7;
    lookup(UA, "R6 disabled channel");
    uc_en = 8'hFF;
    lookup(UB, "R10 unicast miss");

    write_entry(9, MA, 1, 1, 3'd6);
    hash_en = 0;
    lookup(MA, "R6 group via table, hash off");
    uc_en = 8'hBF; hash_en = 1; hash_tbl = 64'd1 << bench_hash(MA);
    lookup(MA, "R6 group entry ignored, hash accepts");
    hash_tbl = 64'd0;
    lookup(MA, "R8 group miss, hash bit clear");
    uc_en = 8'hFF;

    write_entry(2, MB, 1, 0, 3'd1);
    hash_tbl = '1;
    lookup(MB, "R5 reject overrides hash");
    write_entry(2, MB, 0, 0, 3'd1);
    lookup(MB, "R8 group miss, hash bit set");

    write_entry(3, UB, 1, 1, 3'd2);
    write_entry(7, UB, 1, 0, 3'd5);
    lookup(UB, "R7 lower admit wins");
    write_entry(1, UB, 1, 0, 3'd5);
    lookup(UB, "R7 lower reject wins");

    bcast_en = 1;
    lookup(BC, "R9 broadcast on");
    bcast_en = 0;
    lookup(BC, "R9 broadcast off");

    // R3: second lookup offered while busy
    expect_of(UA, ea, ec); pa = res_accept; pc = res_chan;
    start_lookup(UA, st);
    lkp_mac = BC; lkp_valid = 1;
    chk(lkp_ready == 0, "R3 ready low when busy", lkp_ready, 0);
    @(negedge clk); lkp_valid = 0;
    finish_lookup(st, ea, ec, pa, pc, "R3 first address kept");

    // R11: writes during a walk
    expect_of(48'h00_00_00_00_0A_0B, ea, ec); pa = res_accept; pc = res_chan;
    start_lookup(48'h00_00_00_00_0A_0B, st);
    wr_valid = 1; wr_idx = 5'd31; wr_mac = 48'h00_00_00_00_0A_0B; wr_used = 1; wr_admit = 1; wr_chan = 3'd5;
    chk(wr_ready == 1, "R11 first write taken", wr_ready, 1);
    @(negedge clk);
    wr_idx = 5'd30; wr_chan = 3'd6;
    chk(wr_ready == 0, "R11 second write stalled", wr_ready, 0);
    @(negedge clk); wr_valid = 0;
    finish_lookup(st, ea, ec, pa, pc, "R11 old contents used");
    m_valid[31] = 1; m_mac[31] = 48'h00_00_00_00_0A_0B; m_admit[31] = 1; m_chan[31] = 3'd5;
    lookup(48'h00_00_00_00_0A_0B, "R11 write applied");

    // constrained random
    pool[0] = UA; pool[1] = UB; pool[2] = MA; pool[3] = MB; pool[4] = BC; pool[5] = 48'h01_80_C2_00_00_0E;
    for (int n = 0; n < 60; n++) begin
      for (int w = 0; w < 2; w++)
        write_entry(int'($urandom_range(31)), pool[$urandom_range(5)], 1'($urandom),
                    1'($urandom), 3'($urandom));
      uc_en = 8'($urandom); hash_en = 1'($urandom); hash_tbl = {$urandom, $urandom};
      bcast_en = 1'($urandom); mc_chan = 3'($urandom); bc_chan = 3'($urandom);
      if ($urandom_range(3) == 0) lookup({$urandom, 16'($urandom)}, "R8 random addr");
      else lookup(pool[$urandom_range(5)], "R4 random pool");
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule